// File: doc/BRIEF.md
# Result Write-Back Length Controller

This block sits between a block-oriented cipher or hash engine and a memory write port. It decides which result bytes reach memory and where they land. When a job starts, it captures the job configuration and works out the job's shape: how many result blocks the input length produces once it is rounded up to whole blocks, how many zero bytes that rounding adds, and how many bytes each written block carries. It then accepts result blocks from the engine one at a time. Each block that has to be stored is issued as a series of 32-bit writes with byte enables.

In cipher mode every 16-byte result block can be written, or all but the final block can be discarded. In hash mode the engine delivers a single digest, and only a programmed number of its leading bytes is stored. That number is limited to the largest digest size of the selected algorithm. The live destination address is exported on the write port and advances as each write is accepted, so it always shows progress through the job. The busy flag falls only after memory has accepted the last write.

Top module: `wbc_writeback_ctrl`

## Requirements
- R1: After reset, busy, wr_valid and res_ready are low and block_count and pad_bytes read zero.
- R2: In cipher mode (cfg_hash=0) with cfg_last_only=0, each 16-byte result block is written as four full words (wr_be=4'b1111). The writes go to consecutive word addresses starting at cfg_dest with its two low bits forced to zero.
- R3: In cipher mode with cfg_last_only=1, result blocks other than the final one are accepted but not written, and the final block is written starting at the aligned cfg_dest.
- R4: At start, block_count is set to ceil(cfg_len / B) and pad_bytes to B*block_count - cfg_len. B is 16 in cipher mode, 64 in hash mode with cfg_wide=0 and 128 with cfg_wide=1.
- R5: In hash mode the stored byte count is min(cfg_digest_m1+1, M). M comes from {cfg_wide,cfg_alg}: 000=16, 001=20, 010=28, 011=32, 100=48, 101=64, 110=28, 111=32.
- R6: Result byte i is res_data[8i+7:8i]. Write k carries bytes 4k..4k+3 with byte 4k in wr_data[7:0], and wr_be bit j is set exactly when byte 4k+j is among the bytes to store, so a partial final word enables only its low bytes.
- R7: wr_addr holds the current destination and advances by 4 on every accepted write (wr_valid and wr_ready high at a clock edge).
- R8: While wr_valid is high and wr_ready is low, wr_valid, wr_addr, wr_data and wr_be hold their values.
- R9: busy falls at the clock edge that accepts the job's last write, and no write is issued after it.
- R10: A start pulse while busy is ignored (job shape and write stream unchanged). A cipher job with cfg_len=0 finishes without any write or result transfer.
- R11: res_ready is high only while the block is waiting for a result block, never while a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle job start, taken only when idle |
| cfg_hash | input | 1 | 1 = hash job, 0 = cipher job |
| cfg_wide | input | 1 | Hash family: 0 = 32-bit-word family, 1 = 64-bit-word family |
| cfg_alg | input | 2 | Hash algorithm within the family |
| cfg_last_only | input | 1 | Cipher only: store just the final result block |
| cfg_digest_m1 | input | 6 | Hash only: digest bytes to store minus one |
| cfg_dest | input | ADDR_W | Destination start address |
| cfg_len | input | LEN_W | Input length in bytes |
| res_valid | input | 1 | Engine offers a result block |
| res_ready | output | 1 | Controller accepts a result block |
| res_data | input | 8*RES_BYTES | Result block, byte 0 in the low bits |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Live destination address (word aligned) |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables |
| busy | output | 1 | Job in progress |
| block_count | output | LEN_W | Result blocks of the current or last job |
| pad_bytes | output | 8 | Zero bytes added to reach a block boundary |

## Verification
On every cycle the assertions check the shape of the byte enables, the 4-byte address step on each accepted write, and that a stalled write holds steady. They also check that a start pulse during a job leaves the job shape untouched. The scoreboard scenarios are what show the content: which blocks are dropped in last-only mode, the clamped digest length for each algorithm code, the rounding and padding arithmetic, and the exact cycle at which busy falls. They also cover the zero-length job and the ignored start, which involve stimulus order and absence of writes over a whole job.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_WRITE = 2'd2
    } wbc_state_e;

    // Largest digest in bytes for a {family, algorithm} code
    function automatic logic [6:0] digest_max(input logic wide, input logic [1:0] alg);
        case ({wide, alg})
            3'b000:  digest_max = 7'd16;
            3'b001:  digest_max = 7'd20;
            3'b010:  digest_max = 7'd28;
            3'b011:  digest_max = 7'd32;
            3'b100:  digest_max = 7'd48;
            3'b101:  digest_max = 7'd64;
            3'b110:  digest_max = 7'd28;
            default: digest_max = 7'd32;
        endcase
    endfunction

endpackage

// File: rtl/wbc_job_sizer.sv
module wbc_job_sizer #(
    parameter int LEN_W        = 24,
    parameter int NB_W         = 7,
    parameter int CIPHER_BYTES = 16
) (
    input  logic             hash,
    input  logic             wide,
    input  logic [1:0]       alg,
    input  logic [5:0]       digest_m1,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] blocks,
    output logic [7:0]       pad,
    output logic [NB_W-1:0]  nbytes
);
    import wbc_pkg::*;

    localparam int W2 = LEN_W + 8;

    logic [2:0]    sh;
    logic [W2-1:0] sum;
    logic [W2-1:0] rounded;
    logic [6:0]    want;
    logic [6:0]    lim;

    always_comb begin
        sh      = !hash ? 3'd4 : (wide ? 3'd7 : 3'd6);
        sum     = W2'(len) + (W2'(1) << sh) - W2'(1);
        blocks  = LEN_W'(sum >> sh);
        rounded = W2'(blocks) << sh;
        pad     = 8'(rounded - W2'(len));
        want    = 7'(digest_m1) + 7'd1;
        lim     = digest_max(wide, alg);
        nbytes  = hash ? NB_W'((want > lim) ? lim : want) : NB_W'(CIPHER_BYTES);
    end

endmodule

// File: rtl/wbc_word_sel.sv
module wbc_word_sel #(
    parameter int RES_BYTES = 64,
    parameter int IDX_W     = 4,
    parameter int NB_W      = 7
) (
    input  logic [8*RES_BYTES-1:0] data,
    input  logic [IDX_W-1:0]       idx,
    input  logic [NB_W-1:0]        nbytes,
    output logic [31:0]            word,
    output logic [3:0]             be
);
    assign word = data[32*idx +: 32];

    for (genvar j = 0; j < 4; j++) begin : g_be
        logic [NB_W-1:0] pos;
        assign pos   = NB_W'({idx, 2'b00}) + NB_W'(j);
        assign be[j] = pos < nbytes;
    end

endmodule

// File: rtl/wbc_writeback_ctrl.sv
module wbc_writeback_ctrl #(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 24,
    parameter int RES_BYTES    = 64,
    parameter int CIPHER_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cfg_hash,
    input  logic                   cfg_wide,
    input  logic [1:0]             cfg_alg,
    input  logic                   cfg_last_only,
    input  logic [5:0]             cfg_digest_m1,
    input  logic [ADDR_W-1:0]      cfg_dest,
    input  logic [LEN_W-1:0]       cfg_len,
    input  logic                   res_valid,
    output logic                   res_ready,
    input  logic [8*RES_BYTES-1:0] res_data,
    output logic                   wr_valid,
    input  logic                   wr_ready,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [31:0]            wr_data,
    output logic [3:0]             wr_be,
    output logic                   busy,
    output logic [LEN_W-1:0]       block_count,
    output logic [7:0]             pad_bytes
);
    import wbc_pkg::*;

    localparam int RES_W  = 8 * RES_BYTES;
    localparam int NWORDS = RES_BYTES / 4;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int NB_W   = $clog2(RES_BYTES + 1);

    typedef struct packed {
        wbc_state_e         st;
        logic               last_only;
        logic [LEN_W-1:0]   left;
        logic [NB_W-1:0]    nbytes;
        logic [IDX_W-1:0]   widx;
        logic [RES_W-1:0]   data;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   blocks;
        logic [7:0]         pad;
    } wbc_regs_t;

    wbc_regs_t r_d, r_q;

    logic [LEN_W-1:0] sz_blocks;
    logic [7:0]       sz_pad;
    logic [NB_W-1:0]  sz_nbytes;
    logic [IDX_W-1:0] last_idx;

    wbc_job_sizer #(
        .LEN_W(LEN_W), .NB_W(NB_W), .CIPHER_BYTES(CIPHER_BYTES)
    ) u_sizer (
        .hash(cfg_hash), .wide(cfg_wide), .alg(cfg_alg),
        .digest_m1(cfg_digest_m1), .len(cfg_len),
        .blocks(sz_blocks), .pad(sz_pad), .nbytes(sz_nbytes)
    );

    wbc_word_sel #(
        .RES_BYTES(RES_BYTES), .IDX_W(IDX_W), .NB_W(NB_W)
    ) u_sel (
        .data(r_q.data), .idx(r_q.widx), .nbytes(r_q.nbytes),
        .word(wr_data), .be(wr_be)
    );

    assign last_idx = IDX_W'((r_q.nbytes - NB_W'(1)) >> 2);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.last_only = cfg_last_only & ~cfg_hash;
                    r_d.addr      = {cfg_dest[ADDR_W-1:2], 2'b00};
                    r_d.blocks    = sz_blocks;
                    r_d.pad       = sz_pad;
                    r_d.nbytes    = sz_nbytes;
                    r_d.left      = cfg_hash ? LEN_W'(1) : sz_blocks;
                    r_d.st        = (cfg_hash || sz_blocks != '0) ? S_WAIT : S_IDLE;
                end
            end
            S_WAIT: begin
                if (res_valid) begin
                    r_d.data = res_data;
                    r_d.left = r_q.left - LEN_W'(1);
                    r_d.widx = '0;
                    if (!r_q.last_only || r_q.left == LEN_W'(1)) begin
                        r_d.st = S_WRITE;
                    end
                end
            end
            S_WRITE: begin
                if (wr_ready) begin
                    r_d.addr = r_q.addr + ADDR_W'(4);
                    r_d.widx = r_q.widx + IDX_W'(1);
                    if (r_q.widx == last_idx) begin
                        r_d.st = (r_q.left == '0) ? S_IDLE : S_WAIT;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign res_ready   = (r_q.st == S_WAIT);
    assign wr_valid    = (r_q.st == S_WRITE);
    assign wr_addr     = r_q.addr;
    assign busy        = (r_q.st != S_IDLE);
    assign block_count = r_q.blocks;
    assign pad_bytes   = r_q.pad;

    // R6: enables always form a contiguous run from byte 0
    p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be == 4'b0001 || wr_be == 4'b0011 ||
                      wr_be == 4'b0111 || wr_be == 4'b1111));

    // R7: destination steps one word per accepted write
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (wr_addr == $past(wr_addr) + ADDR_W'(4)));

    // R8: stalled write keeps its content
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                     $stable(wr_data) && $stable(wr_be)));

    // R10: start during a job leaves the job shape alone
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(block_count) && $stable(pad_bytes)));

endmodule

// File: tb/wbc_writeback_ctrl_bench.sv
`timescale 1ns/1ps
module wbc_writeback_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cfg_hash = 1'b0;
    logic         cfg_wide = 1'b0;
    logic [1:0]   cfg_alg = 2'd0;
    logic         cfg_last_only = 1'b0;
    logic [5:0]   cfg_digest_m1 = 6'd0;
    logic [31:0]  cfg_dest = 32'd0;
    logic [23:0]  cfg_len = 24'd0;
    logic         res_valid = 1'b0;
    logic         res_ready;
    logic [511:0] res_data = '0;
    logic         wr_valid;
    logic         wr_ready = 1'b0;
    logic [31:0]  wr_addr;
    logic [31:0]  wr_data;
    logic [3:0]   wr_be;
    logic         busy;
    logic [23:0]  block_count;
    logic [7:0]   pad_bytes;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    stall_mode = 0;
    bit    idle_chk = 0;
    string cur_tag = "R1";
    logic [67:0] exp_q[$];

    always #5 clk = ~clk;

    wbc_writeback_ctrl u_wbc_writeback_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_hash(cfg_hash), .cfg_wide(cfg_wide), .cfg_alg(cfg_alg),
        .cfg_last_only(cfg_last_only), .cfg_digest_m1(cfg_digest_m1),
        .cfg_dest(cfg_dest), .cfg_len(cfg_len),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .busy(busy),
        .block_count(block_count), .pad_bytes(pad_bytes)
    );

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_block(input int seed);
        logic [511:0] r;
        for (int i = 0; i < 64; i++) r[8*i +: 8] = 8'(seed * 13 + i * 7 + 1);
        return r;
    endfunction

    function automatic int max_bytes(input bit wide, input int alg);
        int t[8] = '{16, 20, 28, 32, 48, 64, 28, 32};
        return t[(wide ? 4 : 0) + alg];
    endfunction

    // monitor: scoreboard pop/compare, readiness pattern
    always @(negedge clk) begin
        cyc++;
        wr_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        #1;
        if (idle_chk) begin
            idle_chk = 0;
            check({cur_tag, " R9 busy after last write"}, busy == 1'b0, busy, 0);
        end
        if (wr_valid && res_ready) check("R11 res_ready during write", 1'b0, 1, 0);
        if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                check("R9 write after job end", 1'b0, {wr_addr, wr_data, wr_be}, 0);
            end else begin
                logic [67:0] e;
                e = exp_q.pop_front();
                check({cur_tag, " write addr/data/be"}, {wr_addr, wr_data, wr_be} == e,
                      {wr_addr, wr_data, wr_be}, e);
                if (exp_q.size() == 0) idle_chk = 1;
            end
        end
    end

    task automatic run_job(input string tag, input bit hash, input bit wide, input int alg,
                           input bit last_only, input int m1, input logic [31:0] dest,
                           input int len, input int seed, input bit poke);
        int bs, nblk, nbytes, nw, words_total, wait_cyc;
        logic [31:0] a;
        logic [511:0] blk;
        cur_tag = tag;
        bs = !hash ? 16 : (wide ? 128 : 64);
        nblk = (len + bs - 1) / bs;
        nbytes = hash ? ((m1 + 1 > max_bytes(wide, alg)) ? max_bytes(wide, alg) : m1 + 1) : 16;
        nw = (nbytes + 3) / 4;
        a = {dest[31:2], 2'b00};
        words_total = 0;
        for (int b = 0; b < (hash ? 1 : nblk); b++) begin
            if (hash || !last_only || b == nblk - 1) begin
                blk = mk_block(seed + b);
                for (int k = 0; k < nw; k++) begin
                    logic [3:0] be;
                    for (int j = 0; j < 4; j++) be[j] = (4 * k + j) < nbytes;
                    exp_q.push_back({a, blk[32*k +: 32], be});
                    a = a + 32'd4;
                    words_total++;
                end
            end
        end
        @(negedge clk);
        cfg_hash = hash; cfg_wide = wide; cfg_alg = 2'(alg); cfg_last_only = last_only;
        cfg_digest_m1 = 6'(m1); cfg_dest = dest; cfg_len = 24'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R4 block_count"}, block_count == 24'(nblk), block_count, nblk);
        check({tag, " R4 pad_bytes"}, pad_bytes == 8'(nblk * bs - len), pad_bytes, nblk * bs - len);
        for (int b = 0; b < (hash ? 1 : nblk); b++) begin
            wait_cyc = 0;
            while (!res_ready && wait_cyc < 1000) begin
                @(negedge clk);
                wait_cyc++;
            end
            res_valid = 1'b1;
            res_data = mk_block(seed + b);
            @(negedge clk);
            res_valid = 1'b0;
            if (poke && b == 0) begin
                cfg_hash = 1'b1; cfg_len = 24'd500; cfg_dest = 32'hF000;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                @(negedge clk);
                check({tag, " R10 start while busy"}, block_count == 24'(nblk), block_count, nblk);
            end
        end
        wait_cyc = 0;
        while (busy && wait_cyc < 2000) begin
            @(negedge clk);
            wait_cyc++;
        end
        repeat (2) @(negedge clk);
        check({tag, " R9 job finished"}, busy == 1'b0, busy, 0);
        check({tag, " R9 all writes seen"}, exp_q.size() == 0, exp_q.size(), 0);
        check({tag, " R7 final wr_addr"}, wr_addr == {dest[31:2], 2'b00} + 32'(4 * words_total),
              wr_addr, {dest[31:2], 2'b00} + 32'(4 * words_total));
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", busy == 1'b0, busy, 0);
        check("R1 wr_valid", wr_valid == 1'b0, wr_valid, 0);
        check("R1 res_ready", res_ready == 1'b0, res_ready, 0);
        check("R1 counts", block_count == 0 && pad_bytes == 0, block_count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_job("R2 cipher all", 0, 0, 0, 0, 0, 32'h1000, 40, 1, 0);
        stall_mode = 1;
        run_job("R3 cipher last-only", 0, 0, 0, 1, 0, 32'h2000, 64, 5, 0);
        run_job("R5 R6 md5 6 bytes", 1, 0, 0, 0, 5, 32'h2400, 100, 9, 0);
        stall_mode = 0;
        run_job("R5 sha1 clamp", 1, 0, 1, 0, 63, 32'h2800, 10, 11, 0);
        run_job("R6 R4 sha384 41 bytes", 1, 1, 0, 0, 40, 32'h2C00, 129, 13, 0);
        stall_mode = 1;
        run_job("R5 sha512 full", 1, 1, 1, 0, 63, 32'h3400, 128, 17, 0);
        run_job("R5 512/224 clamp", 1, 1, 2, 0, 40, 32'h3800, 1, 19, 0);
        run_job("R10 ignored start", 0, 0, 0, 0, 0, 32'h4000, 32, 21, 1);
        stall_mode = 0;
        run_job("R2 unaligned dest", 0, 0, 0, 0, 0, 32'h3003, 17, 25, 0);

        // R10: zero-length cipher job
        cur_tag = "R10 zero length";
        @(negedge clk);
        cfg_hash = 0; cfg_last_only = 0; cfg_len = 24'd0; cfg_dest = 32'h5000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 zero length busy", busy == 1'b0, busy, 0);
        check("R10 zero length block_count", block_count == 0, block_count, 0);
        repeat (4) @(negedge clk);
        check("R10 zero length no result request", res_ready == 1'b0 && wr_valid == 1'b0, res_ready, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule